// File: doc/BRIEF.md
# Three-Mode Multiply-Accumulate Tree

This block is a shared fixed-point arithmetic datapath with a parameterised number of lanes. Each lane has a pipelined multiplier and a pipelined adder. In dot-product mode the adders form a binary reduction tree over the lane products and give one sum per accepted item. In scale mode the multiplier outputs are tapped early, so every lane returns its own product after the multiplier latency alone. In element-wise mode each lane's adder is fed from that lane's operands and returns A plus or minus B. Each lane has its own add/subtract select.

The tree needs one adder fewer than there are lanes. One extra adder is instantiated so that every lane, the last one included, has an adder for element-wise work. Every lane operand has a zero-force control that replaces it with zero in all modes. The caller uses this when a lane has no valid data.

Items enter on a valid/ready handshake and carry a mode code. The pipelines run freely, so there is no back-pressure on the output side. `out_valid` pulses for one cycle per accepted item at that mode's latency, and the result must be captured in that cycle. `in_ready` does not depend on `in_valid`. It is high when nothing is in flight, or when the requested mode equals the mode of the items in flight. A mode change is therefore held off until the last result of the old mode is on the taps. `busy` shows that accepted items are still in flight.

Top module: `tri_mode_mac`

## Requirements
- R1: Mode code 0 (dot product): `tree_out` equals the signed sum over all lanes of A(x)·B(x). It is valid MUL_LAT + ADD_LAT·log2(LANES) cycles after acceptance (33 with the default parameters).
- R2: Mode code 1 (scale): lane x of `mul_tap` equals the signed product A(x)·B(x), valid MUL_LAT cycles after acceptance.
- R3: Mode codes 2 and 3 (element-wise): lane x of `add_tap` equals A(x)+B(x) when `sub_sel[x]` is 0 and A(x)−B(x) when it is 1. The result is valid ADD_LAT cycles after acceptance, for every lane including lane LANES−1.
- R4: When `a_zero[x]` (or `b_zero[x]`) is 1, lane x uses zero in place of its A (or B) operand, in every mode.
- R5: `out_valid` is high for exactly one cycle per accepted item, at that item's mode latency, and at no other time.
- R6: `busy` is high exactly while some accepted item has not yet reached its output. `in_ready` is high when `busy` is low or the requested mode equals the mode in flight (codes 2 and 3 count as the same mode).
- R7: A request for a different mode while `busy` is high sees `in_ready` low and leaves no trace in the outputs. The request is accepted in the cycle the old mode's last result appears.
- R8: Items of the same mode are accepted one per cycle, back to back, and each result appears on its own cycle.
- R9: After reset, `busy` and `out_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Item offered |
| in_ready | output | 1 | Item can be accepted this cycle |
| in_mode | input | 2 | 0 dot product, 1 scale, 2 or 3 element-wise |
| a_flat | input | LANES·DW | Signed A operands, lane 0 in the low bits |
| b_flat | input | LANES·DW | Signed B operands, lane 0 in the low bits |
| a_zero | input | LANES | Per-lane force of A to zero |
| b_zero | input | LANES | Per-lane force of B to zero |
| sub_sel | input | LANES | Per-lane subtract select for element-wise mode |
| busy | output | 1 | Accepted items still in flight |
| out_valid | output | 1 | Result of one item is on the taps this cycle |
| mul_tap | output | LANES·2·DW | Per-lane multiplier outputs |
| add_tap | output | LANES·(2·DW+log2(LANES)) | Per-lane adder outputs |
| tree_out | output | 2·DW+log2(LANES) | Root of the adder tree |

## Verification
An item accepted at the rising edge that ends cycle c has its result due in cycle c + L. L is 9 for scale, 12 for element-wise and 33 for dot product with the default parameters. The driver records the cycle in which `in_ready` was seen high and queues the expected result with its due cycle. The monitor samples on the falling edge and compares the current cycle count with that due cycle as well as the data. A mode switch is also timed: the first item of a new mode must be accepted exactly in the cycle the previous mode's last result appears.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

  typedef enum logic [1:0] {
    MODE_DOT   = 2'd0,
    MODE_SCALE = 2'd1,
    MODE_ELEM  = 2'd2
  } tmm_mode_e;

  // Codes 2 and 3 both select element-wise operation.
  function automatic tmm_mode_e tmm_norm(input logic [1:0] code);
    if (code[1])      return MODE_ELEM;
    else if (code[0]) return MODE_SCALE;
    else              return MODE_DOT;
  endfunction

  function automatic int tmm_latency(input tmm_mode_e m, input int mul_lat,
                                     input int add_lat, input int tree_lat);
    case (m)
      MODE_SCALE: return mul_lat;
      MODE_ELEM:  return add_lat;
      default:    return tree_lat;
    endcase
  endfunction

endpackage

// File: rtl/tmm_mul_lane.sv
module tmm_mul_lane #(
  parameter int DW      = 16,
  parameter int MUL_LAT = 9,
  localparam int PW     = 2 * DW
) (
  input  logic                 clk,
  input  logic                 za,
  input  logic                 zb,
  input  logic signed [DW-1:0] opa,
  input  logic signed [DW-1:0] opb,
  output logic signed [PW-1:0] prod_q
);

  logic signed [PW-1:0] xa, xb, prod_d;
  logic signed [PW-1:0] pipe [MUL_LAT];

  always_comb begin
    xa     = za ? '0 : PW'(opa);
    xb     = zb ? '0 : PW'(opb);
    prod_d = xa * xb;
  end

  always_ff @(posedge clk) begin
    pipe[0] <= prod_d;
    for (int s = 1; s < MUL_LAT; s++) pipe[s] <= pipe[s-1];
  end

  assign prod_q = pipe[MUL_LAT-1];

endmodule

// File: rtl/tmm_add_node.sv
module tmm_add_node #(
  parameter int DW      = 16,
  parameter int AW      = 34,
  parameter int ADD_LAT = 12
) (
  input  logic                 clk,
  input  logic                 elem,
  input  logic                 sub,
  input  logic                 za,
  input  logic                 zb,
  input  logic signed [DW-1:0] opa_lane,
  input  logic signed [DW-1:0] opb_lane,
  input  logic signed [AW-1:0] tree_a,
  input  logic signed [AW-1:0] tree_b,
  output logic signed [AW-1:0] sum_q
);

  logic signed [AW-1:0] la, lb, xa, xb, sum_d;
  logic signed [AW-1:0] pipe [ADD_LAT];

  // Input mux: lane operands in element-wise mode, tree operands otherwise.
  always_comb begin
    la    = za ? '0 : AW'(opa_lane);
    lb    = zb ? '0 : AW'(opb_lane);
    xa    = elem ? la : tree_a;
    xb    = elem ? lb : tree_b;
    sum_d = (elem && sub) ? (xa - xb) : (xa + xb);
  end

  always_ff @(posedge clk) begin
    pipe[0] <= sum_d;
    for (int s = 1; s < ADD_LAT; s++) pipe[s] <= pipe[s-1];
  end

  assign sum_q = pipe[ADD_LAT-1];

endmodule

// File: rtl/tmm_ctrl.sv
module tmm_ctrl
  import tmm_pkg::*;
#(
  parameter int MUL_LAT  = 9,
  parameter int ADD_LAT  = 12,
  parameter int TREE_LAT = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_mode,
  output logic       in_ready,
  output logic       busy,
  output logic       out_valid,
  output logic       route_elem
);

  tmm_mode_e             req_m, act_m, route_m;
  logic [TREE_LAT-1:0]   vld_sr;
  logic                  fire;
  int                    lat;

  always_comb begin
    req_m     = tmm_norm(in_mode);
    lat       = tmm_latency(act_m, MUL_LAT, ADD_LAT, TREE_LAT);
    busy      = 1'b0;
    out_valid = 1'b0;
    for (int i = 0; i < TREE_LAT; i++) begin
      if (vld_sr[i] && (i < lat - 1))  busy      = 1'b1;
      if (vld_sr[i] && (i == lat - 1)) out_valid = 1'b1;
    end
    in_ready   = !busy || (req_m == act_m);
    fire       = in_valid && in_ready;
    route_m    = fire ? req_m : act_m;
    route_elem = (route_m == MODE_ELEM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
      act_m  <= MODE_DOT;
    end else begin
      // A mode switch only happens once drained; drop stale markers.
      if (fire && (req_m != act_m)) vld_sr <= TREE_LAT'(1);
      else                          vld_sr <= (vld_sr << 1) | TREE_LAT'(fire);
      if (fire) act_m <= req_m;
    end
  end

endmodule

// File: rtl/tri_mode_mac.sv
module tri_mode_mac
  import tmm_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DW      = 16,
  parameter int MUL_LAT = 9,
  parameter int ADD_LAT = 12,
  localparam int DEPTH    = $clog2(LANES),
  localparam int PW       = 2 * DW,
  localparam int AW       = PW + DEPTH,
  localparam int TREE_LAT = MUL_LAT + ADD_LAT * DEPTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_mode,
  input  logic [LANES*DW-1:0]   a_flat,
  input  logic [LANES*DW-1:0]   b_flat,
  input  logic [LANES-1:0]      a_zero,
  input  logic [LANES-1:0]      b_zero,
  input  logic [LANES-1:0]      sub_sel,
  output logic                  busy,
  output logic                  out_valid,
  output logic [LANES*PW-1:0]   mul_tap,
  output logic [LANES*AW-1:0]   add_tap,
  output logic [AW-1:0]         tree_out
);

  logic                 route_elem;
  logic signed [PW-1:0] mul_q [LANES];
  logic signed [AW-1:0] add_q [LANES];
  logic signed [AW-1:0] tin_a [LANES];
  logic signed [AW-1:0] tin_b [LANES];

  tmm_ctrl #(
    .MUL_LAT (MUL_LAT),
    .ADD_LAT (ADD_LAT),
    .TREE_LAT(TREE_LAT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .route_elem(route_elem)
  );

  // Per-lane multiplier and adder; adder index x also serves lane x.
  for (genvar x = 0; x < LANES; x++) begin : g_lane
    tmm_mul_lane #(
      .DW     (DW),
      .MUL_LAT(MUL_LAT)
    ) u_mul (
      .clk   (clk),
      .za    (a_zero[x]),
      .zb    (b_zero[x]),
      .opa   (a_flat[x*DW +: DW]),
      .opb   (b_flat[x*DW +: DW]),
      .prod_q(mul_q[x])
    );

    tmm_add_node #(
      .DW     (DW),
      .AW     (AW),
      .ADD_LAT(ADD_LAT)
    ) u_add (
      .clk     (clk),
      .elem    (route_elem),
      .sub     (sub_sel[x]),
      .za      (a_zero[x]),
      .zb      (b_zero[x]),
      .opa_lane(a_flat[x*DW +: DW]),
      .opb_lane(b_flat[x*DW +: DW]),
      .tree_a  (tin_a[x]),
      .tree_b  (tin_b[x]),
      .sum_q   (add_q[x])
    );

    assign mul_tap[x*PW +: PW] = mul_q[x];
    assign add_tap[x*AW +: AW] = add_q[x];
  end

  // Tree wiring: level lv occupies adders BASE .. BASE+CNT-1.
  for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
    localparam int BASE = LANES - (LANES >> lv);
    localparam int CNT  = LANES >> (lv + 1);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      if (lv == 0) begin : g_leaf
        assign tin_a[BASE+j] = AW'(mul_q[2*j]);
        assign tin_b[BASE+j] = AW'(mul_q[2*j+1]);
      end else begin : g_inner
        localparam int PREV = LANES - (LANES >> (lv - 1));
        assign tin_a[BASE+j] = add_q[PREV+2*j];
        assign tin_b[BASE+j] = add_q[PREV+2*j+1];
      end
    end
  end

  // The extra adder exists for element-wise work on the last lane only.
  assign tin_a[LANES-1] = '0;
  assign tin_b[LANES-1] = '0;

  assign tree_out = add_q[LANES-2];

endmodule

// File: rtl/tmm_checker.sv
module tmm_checker
  import tmm_pkg::*;
#(
  parameter int MUL_LAT  = 9,
  parameter int ADD_LAT  = 12,
  parameter int TREE_LAT = 33
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_mode,
  input logic       busy,
  input logic       out_valid
);

  logic                fire;
  tmm_mode_e           nm, ck_mode;
  logic [MUL_LAT-1:0]  sc_h;
  logic [ADD_LAT-1:0]  el_h;
  logic [TREE_LAT-1:0] dt_h;
  logic                due_now;

  assign fire    = in_valid && in_ready;
  assign nm      = tmm_norm(in_mode);
  assign due_now = sc_h[MUL_LAT-1] | el_h[ADD_LAT-1] | dt_h[TREE_LAT-1];

  // Independent per-mode histories of acceptances.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_h    <= '0;
      el_h    <= '0;
      dt_h    <= '0;
      ck_mode <= MODE_DOT;
    end else begin
      sc_h <= (sc_h << 1) | MUL_LAT'(fire && (nm == MODE_SCALE));
      el_h <= (el_h << 1) | ADD_LAT'(fire && (nm == MODE_ELEM));
      dt_h <= (dt_h << 1) | TREE_LAT'(fire && (nm == MODE_DOT));
      if (fire) ck_mode <= nm;
    end
  end

  AST_OUT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == due_now); // R5

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready); // R6

  AST_FIRE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy || out_valid)); // R6

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($past(busy) || $past(fire))); // R6

  AST_MODE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && (nm != ck_mode)) |-> !in_ready); // R7

endmodule

bind tri_mode_mac tmm_checker #(
  .MUL_LAT (MUL_LAT),
  .ADD_LAT (ADD_LAT),
  .TREE_LAT(TREE_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_mode  (in_mode),
  .busy     (busy),
  .out_valid(out_valid)
);

// File: tb/tb_tri_mode_mac.sv
module tb_tri_mode_mac;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int DW         = 16;
  localparam int MUL_LAT    = 9;
  localparam int ADD_LAT    = 12;
  localparam int DEPTH      = $clog2(LANES);
  localparam int PW         = 2 * DW;
  localparam int AW         = PW + DEPTH;
  localparam int TREE_LAT   = MUL_LAT + ADD_LAT * DEPTH;
  localparam int WATCHDOG   = 20000;

  logic                clk, rst_n, in_valid, in_ready, busy, out_valid;
  logic [1:0]          in_mode;
  logic [LANES*DW-1:0] a_flat, b_flat;
  logic [LANES-1:0]    a_zero, b_zero, sub_sel;
  logic [LANES*PW-1:0] mul_tap;
  logic [LANES*AW-1:0] add_tap;
  logic [AW-1:0]       tree_out;

  tri_mode_mac #(
    .LANES(LANES), .DW(DW), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .a_flat(a_flat), .b_flat(b_flat), .a_zero(a_zero),
    .b_zero(b_zero), .sub_sel(sub_sel), .busy(busy), .out_valid(out_valid),
    .mul_tap(mul_tap), .add_tap(add_tap), .tree_out(tree_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  int                  q_mode [$];
  int                  q_due  [$];
  string               q_tag  [$];
  logic [LANES*PW-1:0] q_mul  [$];
  logic [LANES*AW-1:0] q_add  [$];
  logic [AW-1:0]       q_tree [$];

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL all: watchdog act=%0d exp=<%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Monitor: pops one expected item per out_valid and checks cycle and data.
  int                  m_mode, m_due;
  string               m_tag;
  logic [LANES*PW-1:0] m_mul;
  logic [LANES*AW-1:0] m_add;
  logic [AW-1:0]       m_tree;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_mode.size() == 0) begin
        chk("R5 out_valid with nothing pending", 256'(1), 256'(0));
      end else begin
        m_mode = q_mode.pop_front();
        m_due  = q_due.pop_front();
        m_tag  = q_tag.pop_front();
        m_mul  = q_mul.pop_front();
        m_add  = q_add.pop_front();
        m_tree = q_tree.pop_front();
        chk({"R5 due cycle of ", m_tag}, 256'(cyc), 256'(m_due));
        case (m_mode)
          0:       chk(m_tag, 256'(tree_out), 256'(m_tree));
          1:       chk(m_tag, 256'(mul_tap),  256'(m_mul));
          default: chk(m_tag, 256'(add_tap),  256'(m_add));
        endcase
      end
    end
  end

  // Driver: called at a falling edge; returns the cycle of acceptance.
  task automatic send(input logic [1:0] code, input logic [LANES*DW-1:0] a,
                      input logic [LANES*DW-1:0] b, input logic [LANES-1:0] za,
                      input logic [LANES-1:0] zb, input logic [LANES-1:0] sub,
                      input string tag, output int acc);
    logic [LANES*PW-1:0] em;
    logic [LANES*AW-1:0] ea;
    longint              tsum;
    logic [63:0]         tv;
    int                  lat;
    in_valid = 1'b1; in_mode = code; a_flat = a; b_flat = b;
    a_zero = za; b_zero = zb; sub_sel = sub;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    acc  = cyc;
    tsum = 0;
    for (int x = 0; x < LANES; x++) begin
      longint va = za[x] ? 64'sd0 : longint'($signed(a[x*DW +: DW]));
      longint vb = zb[x] ? 64'sd0 : longint'($signed(b[x*DW +: DW]));
      longint p  = va * vb;
      longint s  = sub[x] ? (va - vb) : (va + vb);
      tv = p;  em[x*PW +: PW] = tv[PW-1:0];
      tv = s;  ea[x*AW +: AW] = tv[AW-1:0];
      tsum = tsum + p;
    end
    tv  = tsum;
    lat = (code == 2'd0) ? TREE_LAT : (code == 2'd1) ? MUL_LAT : ADD_LAT;
    q_mode.push_back(code[1] ? 2 : int'(code));
    q_due.push_back(acc + lat);
    q_tag.push_back(tag);
    q_mul.push_back(em);
    q_add.push_back(ea);
    q_tree.push_back(tv[AW-1:0]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  int acc0, acc1;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0;
    a_flat = '0; b_flat = '0; a_zero = '0; b_zero = '0; sub_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R9 busy after reset",      256'(busy),      256'(0));
    chk("R9 out_valid after reset", 256'(out_valid), 256'(0));
    chk("R9 in_ready after reset",  256'(in_ready),  256'(1));
    @(negedge clk);

    // Dot products, then a back-to-back burst.
    send(2'd0, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5},
         4'h0, 4'h0, 4'h0, "R1 dot small", acc0);
    send(2'd0, {16'hFFFF, 16'h8000, 16'd100, 16'hFFF6}, {16'd3, 16'h8000, 16'hFF9C, 16'd7},
         4'h0, 4'h0, 4'h0, "R8 burst dot signed", acc0);
    send(2'd0, {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF}, {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
         4'h0, 4'h0, 4'h0, "R8 burst dot max", acc1);
    chk("R8 consecutive acceptance", 256'(acc1), 256'(acc0 + 1));
    send(2'd0, {16'd9, 16'd9, 16'd9, 16'd9}, {16'd2, 16'd2, 16'd2, 16'd2},
         4'b0101, 4'b1000, 4'h0, "R4 dot zero force", acc0);

    // Different mode while busy: held off, no trace.
    in_valid = 1'b1; in_mode = 2'd1;
    #1;
    chk("R7 busy during dot", 256'(busy), 256'(1));
    chk("R7 mode change refused", 256'(in_ready), 256'(0));
    @(negedge clk);
    #1;
    chk("R7 mode change still refused", 256'(in_ready), 256'(0));
    in_valid = 1'b0;
    @(negedge clk);

    // Switch to scale: accepted the cycle the last dot result appears.
    send(2'd1, {16'd4, 16'hFFFE, 16'h8000, 16'd300}, {16'd5, 16'd6, 16'h8000, 16'hFF00},
         4'h0, 4'h0, 4'h0, "R2 scale products", acc1);
    chk("R7 switch when last result shows", 256'(acc1), 256'(acc0 + TREE_LAT));
    send(2'd1, {16'd11, 16'd12, 16'd13, 16'd14}, {16'd2, 16'd2, 16'd2, 16'd2},
         4'b0010, 4'b0100, 4'h0, "R4 scale zero force", acc0);

    // Element-wise with both codes.
    send(2'd2, {16'd50, 16'hFFF0, 16'h7FFF, 16'd10}, {16'd20, 16'd16, 16'h7FFF, 16'h8000},
         4'h0, 4'h0, 4'b1010, "R3 elem mixed add sub", acc0);
    send(2'd3, {16'h8000, 16'd1, 16'd2, 16'd3}, {16'h7FFF, 16'd4, 16'd5, 16'd6},
         4'h0, 4'h0, 4'b1001, "R3 elem code3 last lane", acc1);
    chk("R6 codes 2 and 3 share a mode", 256'(acc1), 256'(acc0 + 1));
    send(2'd2, {16'd7, 16'd7, 16'd7, 16'd7}, {16'd3, 16'd3, 16'd3, 16'd3},
         4'b1100, 4'b0110, 4'b0101, "R4 elem zero force", acc0);

    // Back to dot after element-wise.
    send(2'd0, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, {16'd1, 16'd2, 16'd3, 16'd4},
         4'h0, 4'h0, 4'hF, "R1 dot after elem", acc1);
    chk("R7 switch after elem drain", 256'(acc1), 256'(acc0 + ADD_LAT));

    repeat (TREE_LAT + 4) @(negedge clk);
    #1;
    chk("R5 every result delivered", 256'(q_mode.size()), 256'(0));
    chk("R6 idle busy",     256'(busy),     256'(0));
    chk("R6 idle in_ready", 256'(in_ready), 256'(1));
    finish_run();
  end

endmodule